// File: doc/BRIEF.md
# Supervisor Enqueue Command Issue Unit

This unit runs the back half of a supervisor-level enqueue-command operation. A 512-bit command payload, already fetched from memory, arrives together with the destination address, the current privilege level, the execution mode, a feature-enable bit, a lock-prefix indicator and a translation-fault flag. The translation-fault flag summarises the segmentation, paging and canonical-address checks, which are done elsewhere.

The unit first checks for faults in a fixed priority order. If there is no fault, it rewrites the payload into supervisor command form. The low 20 bits keep the address-space tag, bits 30:20 are cleared, and the remaining bits pass through, so bit 31 carries the user/supervisor indicator. It then issues a single 64-byte store request on a valid/ready channel. That store is marked as non-allocating and non-combinable. The unit waits for one status beat and turns it into arithmetic flags: only the zero flag can be set, and it signals a retry.

Only one operation is in flight at a time. A new request is taken only while the unit is idle. Completion, whether by fault or by response, is marked by a one-cycle `done_o` pulse.

Top module: `enq_cmd_issue`

## Requirements
- R1: Store data bits 19:0 equal payload bits 19:0.
- R2: Store data bits 30:20 are zero whatever the payload holds there.
- R3: Store data bits 511:31 equal the payload bits 511:31; bit 31 (0 user, 1 supervisor) is not altered.
- R4: When the feature-enable bit is low or the lock indicator is high, the fault code is 1 (undefined opcode). This check outranks every other check and no store is issued.
- R5: Mode codes are 0 real, 1 protected, 2 compatibility, 3 64-bit and 4 virtual-8086; codes 5 to 7 act as protected. Mode 4 gives fault code 2 (general protection, mode), ranked directly after R4.
- R6: A privilege level other than 0 in modes 1, 2, 3 (or 5 to 7) gives fault code 3 (general protection, privilege), ranked after R5. Privilege is not checked in real mode.
- R7: An address whose low 6 bits are not zero gives fault code 4 (general protection, alignment), ranked after R6. The translation-fault input gives fault code 5, ranked last. A fault is reported as `done_o`=1 with `fault_o` set in the cycle after acceptance, and no store request is made.
- R8: With no fault, `st_valid_o` rises in the cycle after acceptance. `st_data_o` and `st_addr_o` stay stable until the cycle after `st_ready_i` is seen high. `st_nocache_o` is high with every request.
- R9: After the store handshake the unit takes exactly one response beat and pulses `done_o` for one cycle after it. A response outside that wait, and a request while busy, are ignored.
- R10: `flags_o` bits are [0] CF, [1] PF, [2] AF, [3] ZF, [4] SF, [5] OF. A retry response sets ZF and a success response clears it, with all other bits zero in both cases. A fault leaves `flags_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Operation request, taken when idle |
| req_payload_i | input | 512 | Loaded command payload |
| req_addr_i | input | 48 | Destination address |
| req_cpl_i | input | 2 | Current privilege level |
| req_mode_i | input | 3 | Execution mode code |
| feat_en_i | input | 1 | Feature enabled |
| lock_i | input | 1 | Lock prefix present |
| xlat_fault_i | input | 1 | Fault from address translation checks |
| busy_o | output | 1 | Operation in progress |
| st_valid_o | output | 1 | Store request valid |
| st_ready_i | input | 1 | Store request accepted |
| st_addr_o | output | 48 | Store address |
| st_data_o | output | 512 | Formatted command data |
| st_nocache_o | output | 1 | No-allocate, no-merge attribute |
| rsp_valid_i | input | 1 | Status beat valid |
| rsp_retry_i | input | 1 | Status: 1 retry, 0 success |
| done_o | output | 1 | Completion pulse |
| fault_o | output | 3 | Fault code, valid with done_o |
| flags_o | output | 6 | Arithmetic flags |

## Verification
A fault is due at the first falling edge after the accepting rising edge, together with `done_o`. The store request is also due at that first falling edge. The request drops one edge after the ready handshake, and `done_o` with the flags follows one edge after the response beat. The bench drives every input at a falling edge and samples at the next falling edge. Each result is therefore read exactly one register stage after the stimulus that causes it. During the stall cycles before ready, the request is resampled at every falling edge to confirm it is held.

// File: rtl/enq_pkg.sv
package enq_pkg;

    typedef enum logic [2:0] {
        MODE_REAL   = 3'd0,
        MODE_PROT   = 3'd1,
        MODE_COMPAT = 3'd2,
        MODE_LONG   = 3'd3,
        MODE_V86    = 3'd4
    } exec_mode_e;

    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_UD    = 3'd1,
        FLT_MODE  = 3'd2,
        FLT_PRIV  = 3'd3,
        FLT_ALIGN = 3'd4,
        FLT_XLAT  = 3'd5
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT
    } issue_state_e;

    typedef struct packed {
        logic of_f;
        logic sf_f;
        logic zf_f;
        logic af_f;
        logic pf_f;
        logic cf_f;
    } arith_flags_t;

    localparam int FLAG_W = $bits(arith_flags_t);

    function automatic arith_flags_t status_to_flags(input logic retry);
        arith_flags_t f;
        f      = '0;
        f.zf_f = retry;
        return f;
    endfunction

endpackage

// File: rtl/enq_fault_check.sv
module enq_fault_check
    import enq_pkg::*;
#(
    parameter int ADDR_W     = 48,
    parameter int ALIGN_BITS = 6
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        cpl_i,
    input  logic [2:0]        mode_i,
    input  logic              feat_en_i,
    input  logic              lock_i,
    input  logic              xlat_fault_i,
    output fault_e            fault_o
);
    logic undef_hit;
    logic mode_hit;
    logic priv_hit;
    logic align_hit;

    always_comb begin
        undef_hit = !feat_en_i || lock_i;
        mode_hit  = (mode_i == MODE_V86);
        priv_hit  = (mode_i != MODE_REAL) && (cpl_i != 2'd0);
        align_hit = (addr_i[ALIGN_BITS-1:0] != '0);

        if (undef_hit)         fault_o = FLT_UD;
        else if (mode_hit)     fault_o = FLT_MODE;
        else if (priv_hit)     fault_o = FLT_PRIV;
        else if (align_hit)    fault_o = FLT_ALIGN;
        else if (xlat_fault_i) fault_o = FLT_XLAT;
        else                   fault_o = FLT_NONE;
    end
endmodule

// File: rtl/enq_cmd_format.sv
module enq_cmd_format #(
    parameter int DATA_W   = 512,
    parameter int TAG_W    = 20,
    parameter int PRIV_POS = 31
) (
    input  logic [DATA_W-1:0] src_i,
    output logic [DATA_W-1:0] cmd_o
);
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (b >= TAG_W && b < PRIV_POS) begin : g_clear
            assign cmd_o[b] = 1'b0;
        end else begin : g_pass
            assign cmd_o[b] = src_i[b];
        end
    end
endmodule

// File: rtl/enq_issue_ctrl.sv
module enq_issue_ctrl
    import enq_pkg::*;
#(
    parameter int DATA_W = 512,
    parameter int ADDR_W = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    input  fault_e            fault_i,
    input  logic [DATA_W-1:0] cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              busy_o,
    output logic              st_valid_o,
    input  logic              st_ready_i,
    output logic [ADDR_W-1:0] st_addr_o,
    output logic [DATA_W-1:0] st_data_o,
    input  logic              rsp_valid_i,
    input  logic              rsp_retry_i,
    output logic              done_o,
    output fault_e            fault_o,
    output arith_flags_t      flags_o
);
    issue_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            st_valid_o <= 1'b0;
            st_addr_o  <= '0;
            st_data_o  <= '0;
            done_o     <= 1'b0;
            fault_o    <= FLT_NONE;
            flags_o    <= '0;
        end else begin
            done_o  <= 1'b0;
            fault_o <= FLT_NONE;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid_i) begin
                        if (fault_i != FLT_NONE) begin
                            done_o  <= 1'b1;
                            fault_o <= fault_i;
                        end else begin
                            st_valid_o <= 1'b1;
                            st_data_o  <= cmd_i;
                            st_addr_o  <= addr_i;
                            state_q    <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (st_ready_i) begin
                        st_valid_o <= 1'b0;
                        state_q    <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (rsp_valid_i) begin
                        done_o  <= 1'b1;
                        flags_o <= status_to_flags(rsp_retry_i);
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/enq_cmd_issue.sv
module enq_cmd_issue
    import enq_pkg::*;
#(
    parameter int DATA_W     = 512,
    parameter int ADDR_W     = 48,
    parameter int LINE_BYTES = 64,
    parameter int TAG_W      = 20,
    parameter int PRIV_POS   = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    input  logic [DATA_W-1:0] req_payload_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [1:0]        req_cpl_i,
    input  logic [2:0]        req_mode_i,
    input  logic              feat_en_i,
    input  logic              lock_i,
    input  logic              xlat_fault_i,
    output logic              busy_o,
    output logic              st_valid_o,
    input  logic              st_ready_i,
    output logic [ADDR_W-1:0] st_addr_o,
    output logic [DATA_W-1:0] st_data_o,
    output logic              st_nocache_o,
    input  logic              rsp_valid_i,
    input  logic              rsp_retry_i,
    output logic              done_o,
    output logic [2:0]        fault_o,
    output logic [5:0]        flags_o
);
    localparam int ALIGN_BITS = $clog2(LINE_BYTES);

    fault_e            fault_d;
    fault_e            fault_q;
    arith_flags_t      flags_q;
    logic [DATA_W-1:0] cmd_d;
    logic              accept;

    assign accept = req_valid_i && !busy_o;

    enq_fault_check #(
        .ADDR_W     (ADDR_W),
        .ALIGN_BITS (ALIGN_BITS)
    ) u_fault (
        .addr_i       (req_addr_i),
        .cpl_i        (req_cpl_i),
        .mode_i       (req_mode_i),
        .feat_en_i    (feat_en_i),
        .lock_i       (lock_i),
        .xlat_fault_i (xlat_fault_i),
        .fault_o      (fault_d)
    );

    enq_cmd_format #(
        .DATA_W   (DATA_W),
        .TAG_W    (TAG_W),
        .PRIV_POS (PRIV_POS)
    ) u_fmt (
        .src_i (req_payload_i),
        .cmd_o (cmd_d)
    );

    enq_issue_ctrl #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_valid_i (accept),
        .fault_i     (fault_d),
        .cmd_i       (cmd_d),
        .addr_i      (req_addr_i),
        .busy_o      (busy_o),
        .st_valid_o  (st_valid_o),
        .st_ready_i  (st_ready_i),
        .st_addr_o   (st_addr_o),
        .st_data_o   (st_data_o),
        .rsp_valid_i (rsp_valid_i),
        .rsp_retry_i (rsp_retry_i),
        .done_o      (done_o),
        .fault_o     (fault_q),
        .flags_o     (flags_q)
    );

    assign st_nocache_o = st_valid_o;
    assign fault_o      = fault_q;
    assign flags_o      = flags_q;
endmodule

// File: rtl/enq_cmd_issue_chk.sv
module enq_cmd_issue_chk #(
    parameter int DATA_W     = 512,
    parameter int ADDR_W     = 48,
    parameter int LINE_BYTES = 64,
    parameter int TAG_W      = 20,
    parameter int PRIV_POS   = 31
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid_i,
    input logic [2:0]        req_mode_i,
    input logic              feat_en_i,
    input logic              lock_i,
    input logic              busy_o,
    input logic              st_valid_o,
    input logic              st_ready_i,
    input logic [ADDR_W-1:0] st_addr_o,
    input logic [DATA_W-1:0] st_data_o,
    input logic              st_nocache_o,
    input logic              done_o,
    input logic [2:0]        fault_o,
    input logic [5:0]        flags_o
);
    localparam int ALIGN_BITS = $clog2(LINE_BYTES);

    AST_UD_FIRST: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && !busy_o && (!feat_en_i || lock_i)) |=> (done_o && fault_o == 3'd1 && !st_valid_o)); // R4

    AST_V86_FAULT: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && !busy_o && feat_en_i && !lock_i && req_mode_i == 3'd4) |=> (done_o && fault_o == 3'd2)); // R5

    AST_FIELD_CLEAR: assert property (@(posedge clk) disable iff (rst)
        st_valid_o |-> (st_data_o[PRIV_POS-1:TAG_W] == '0)); // R2

    AST_ALIGNED_STORE: assert property (@(posedge clk) disable iff (rst)
        st_valid_o |-> (st_addr_o[ALIGN_BITS-1:0] == '0)); // R7

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (st_valid_o && !st_ready_i) |=> (st_valid_o && $stable(st_data_o) && $stable(st_addr_o))); // R8

    AST_NOCACHE_ATTR: assert property (@(posedge clk) disable iff (rst)
        st_valid_o |-> st_nocache_o); // R8

    AST_SINGLE_STORE: assert property (@(posedge clk) disable iff (rst)
        (st_valid_o && st_ready_i) |=> !st_valid_o); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R9

    AST_FAULT_QUAL: assert property (@(posedge clk) disable iff (rst)
        (fault_o != 3'd0) |-> (done_o && !st_valid_o)); // R7

    AST_FLAGS_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (flags_o & 6'b110111) == 6'b0); // R10
endmodule

bind enq_cmd_issue enq_cmd_issue_chk #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .TAG_W      (TAG_W),
    .PRIV_POS   (PRIV_POS)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid_i  (req_valid_i),
    .req_mode_i   (req_mode_i),
    .feat_en_i    (feat_en_i),
    .lock_i       (lock_i),
    .busy_o       (busy_o),
    .st_valid_o   (st_valid_o),
    .st_ready_i   (st_ready_i),
    .st_addr_o    (st_addr_o),
    .st_data_o    (st_data_o),
    .st_nocache_o (st_nocache_o),
    .done_o       (done_o),
    .fault_o      (fault_o),
    .flags_o      (flags_o)
);

// File: tb/enq_cmd_issue_bench.sv
module enq_cmd_issue_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 512;
    localparam int ADDR_W     = 48;
    localparam int NVEC       = 12;
    localparam logic [31:0] FIELD_MASK = 32'h7FF0_0000;

    // {stall[3], exp_zf, exp_fault[3], retry, xf, misalign, lock, feat, cpl[2], mode[3], word[32]}
    localparam logic [48:0] VECS [NVEC] = '{
        {3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 3'd3, 32'hFFFF_FFFF},
        {3'd2, 1'b1, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 3'd3, 32'h8012_3456},
        {3'd0, 1'b0, 3'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3, 3'd4, 32'h1111_1111},
        {3'd0, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 3'd3, 32'h2222_2222},
        {3'd0, 1'b0, 3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 2'd3, 3'd4, 32'h3333_3333},
        {3'd0, 1'b0, 3'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 2'd3, 3'd1, 32'h4444_4444},
        {3'd0, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 3'd2, 32'h5555_5555},
        {3'd1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 3'd0, 32'h7FFF_FFFF},
        {3'd0, 1'b0, 3'd4, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 3'd3, 32'h6666_6666},
        {3'd0, 1'b0, 3'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 3'd3, 32'h7777_7777},
        {3'd3, 1'b1, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 3'd1, 32'hFFF0_0001},
        {3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 3'd2, 32'h0000_ABCD}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid_i = 1'b0;
    logic [DATA_W-1:0] req_payload_i = '0;
    logic [ADDR_W-1:0] req_addr_i = '0;
    logic [1:0]        req_cpl_i = '0;
    logic [2:0]        req_mode_i = '0;
    logic              feat_en_i = 1'b1;
    logic              lock_i = 1'b0;
    logic              xlat_fault_i = 1'b0;
    logic              busy_o;
    logic              st_valid_o;
    logic              st_ready_i = 1'b0;
    logic [ADDR_W-1:0] st_addr_o;
    logic [DATA_W-1:0] st_data_o;
    logic              st_nocache_o;
    logic              rsp_valid_i = 1'b0;
    logic              rsp_retry_i = 1'b0;
    logic              done_o;
    logic [2:0]        fault_o;
    logic [5:0]        flags_o;

    int n_checks = 0;
    int n_errs   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    enq_cmd_issue u_enq_cmd_issue (
        .clk           (clk),
        .rst           (rst),
        .req_valid_i   (req_valid_i),
        .req_payload_i (req_payload_i),
        .req_addr_i    (req_addr_i),
        .req_cpl_i     (req_cpl_i),
        .req_mode_i    (req_mode_i),
        .feat_en_i     (feat_en_i),
        .lock_i        (lock_i),
        .xlat_fault_i  (xlat_fault_i),
        .busy_o        (busy_o),
        .st_valid_o    (st_valid_o),
        .st_ready_i    (st_ready_i),
        .st_addr_o     (st_addr_o),
        .st_data_o     (st_data_o),
        .st_nocache_o  (st_nocache_o),
        .rsp_valid_i   (rsp_valid_i),
        .rsp_retry_i   (rsp_retry_i),
        .done_o        (done_o),
        .fault_o       (fault_o),
        .flags_o       (flags_o)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
        finish_run();
    end

    initial begin
        logic [DATA_W-1:0] exp_data;
        logic [ADDR_W-1:0] exp_addr;
        logic [5:0]        prev_flags;
        logic [5:0]        exp_flags;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!st_valid_o && !done_o && !busy_o, "reset R8 R9 idle outputs",
              {61'd0, st_valid_o, done_o, busy_o}, 64'd0);
        check(flags_o == 6'd0 && fault_o == 3'd0, "reset R10 flags/fault",
              {55'd0, fault_o, flags_o}, 64'd0);
        prev_flags = 6'd0;

        for (int i = 0; i < NVEC; i++) begin
            logic [48:0] v;
            logic [31:0] word;
            logic [2:0]  xfault;
            logic [2:0]  stall;
            v      = VECS[i];
            word   = v[31:0];
            xfault = v[44:42];
            stall  = v[48:46];
            exp_flags = v[45] ? 6'b001000 : 6'b000000;

            @(negedge clk);
            req_valid_i   = 1'b1;
            req_payload_i = {{15{32'h1357_9BDF ^ word}}, word};
            req_addr_i    = 48'h0000_1234_5000 + 48'(i * 64) + (v[39] ? 48'd8 : 48'd0);
            req_mode_i    = v[34:32];
            req_cpl_i     = v[36:35];
            feat_en_i     = v[37];
            lock_i        = v[38];
            xlat_fault_i  = v[40];
            exp_data = req_payload_i;
            exp_data[31:0] = word & ~FIELD_MASK;
            exp_addr = req_addr_i;
            @(negedge clk);
            req_valid_i = 1'b0;

            if (xfault != 3'd0) begin
                // R4 R5 R6 R7: fault code by priority, reported with done
                check(done_o && fault_o == xfault, "R4/R5/R6/R7 fault code priority",
                      {60'd0, done_o, fault_o}, {60'd1, xfault});
                check(!st_valid_o, "R7 no store on fault", {63'd0, st_valid_o}, 64'd0);
                check(flags_o == prev_flags, "R10 fault keeps flags",
                      {58'd0, flags_o}, {58'd0, prev_flags});
            end else begin
                check(st_valid_o && st_nocache_o, "R8 store valid with nocache",
                      {62'd0, st_valid_o, st_nocache_o}, 64'd3);
                check(st_data_o[19:0] == exp_data[19:0], "R1 tag bits",
                      {44'd0, st_data_o[19:0]}, {44'd0, exp_data[19:0]});
                check(st_data_o[30:20] == 11'd0, "R2 cleared field",
                      {53'd0, st_data_o[30:20]}, 64'd0);
                check(st_data_o[DATA_W-1:31] == exp_data[DATA_W-1:31], "R3 upper bits",
                      st_data_o[94:31], exp_data[94:31]);
                check(st_addr_o == exp_addr, "R8 store address",
                      {16'd0, st_addr_o}, {16'd0, exp_addr});
                for (int s = 0; s < int'(stall); s++) begin
                    @(negedge clk);
                    check(st_valid_o && st_data_o == exp_data && st_addr_o == exp_addr,
                          "R8 held during stall", {63'd0, st_valid_o}, 64'd1);
                end
                st_ready_i = 1'b1;
                @(negedge clk);
                st_ready_i = 1'b0;
                check(!st_valid_o && !done_o, "R9 one store then wait",
                      {62'd0, st_valid_o, done_o}, 64'd0);
                rsp_valid_i = 1'b1;
                rsp_retry_i = v[41];
                @(negedge clk);
                rsp_valid_i = 1'b0;
                rsp_retry_i = 1'b0;
                check(done_o && fault_o == 3'd0, "R9 done after response",
                      {60'd0, done_o, fault_o}, 64'h8);
                check(flags_o == exp_flags, "R10 status flags",
                      {58'd0, flags_o}, {58'd0, exp_flags});
                prev_flags = exp_flags;
            end
            @(negedge clk);
            check(!done_o, "R9 done single pulse", {63'd0, done_o}, 64'd0);
        end

        // Directed: request and response while busy are ignored (R9)
        @(negedge clk);
        req_valid_i   = 1'b1;
        req_payload_i = '0;
        req_addr_i    = 48'h0000_0000_8000;
        req_mode_i    = 3'd3;
        req_cpl_i     = 2'd0;
        feat_en_i     = 1'b1;
        lock_i        = 1'b0;
        xlat_fault_i  = 1'b0;
        @(negedge clk);
        req_addr_i  = 48'h0000_0000_9000;
        rsp_valid_i = 1'b1;
        rsp_retry_i = 1'b1;
        @(negedge clk);
        req_valid_i = 1'b0;
        rsp_valid_i = 1'b0;
        check(st_valid_o && st_addr_o == 48'h0000_0000_8000 && !done_o,
              "R9 busy ignores request and early response",
              {16'd0, st_addr_o}, 64'h8000);
        st_ready_i = 1'b1;
        @(negedge clk);
        st_ready_i = 1'b0;
        @(negedge clk);
        check(!done_o && busy_o, "R9 still waiting for response",
              {62'd0, done_o, busy_o}, 64'd1);
        rsp_valid_i = 1'b1;
        rsp_retry_i = 1'b0;
        @(negedge clk);
        rsp_valid_i = 1'b0;
        check(done_o && flags_o == 6'd0, "R10 success clears ZF",
              {57'd0, done_o, flags_o}, 64'h40);
        @(negedge clk);
        check(!busy_o && !st_valid_o, "R9 returns idle",
              {62'd0, busy_o, st_valid_o}, 64'd0);

        finish_run();
    end
endmodule